// File: doc/BRIEF.md
# Serial Configuration Loader for a Dual-Channel Synthesizer

This block accepts configuration words for two frequency synthesizer channels over a three-wire serial link: a data line, a serial clock and a load strobe. The three wires are oversampled and synchronized on a fast system clock. Each rising edge of the serial clock shifts one data bit into a 22-bit shift register, most significant bit first. A rising edge of the load strobe copies the register into one of four holding latches. The two bits shifted in last choose the latch.

Each channel owns two latches. The reference latch holds a reference divide ratio and the phase-detector and charge-pump mode bits. The feedback latch holds the swallow count, the main counter value, the prescaler modulus select and the power-down request. The loader decodes every field into its own registered output. These outputs change only when their latch is loaded. A one-cycle strobe marks which latch was updated. A load that arrives before a full word has been shifted still captures the register as it stands, and it raises a short-frame flag.

Top module: `syn_cfg_loader`

## Requirements
- R1: On each synchronized rising edge of `ser_clk_i`, the shift register takes `ser_data_i` into bit 0 and moves every other bit up one place. After 22 edges, the first bit sent sits at bit 21 of the word.
- R2: On a synchronized rising edge of `ser_le_i`, the word is captured into the latch selected by word bits [1:0] (the last two bits sent). Code 0 selects the channel-2 reference latch, 1 the channel-1 reference latch, 2 the channel-2 feedback latch and 3 the channel-1 feedback latch.
- R3: Reference latch field map: divide ratio = word[16:2] (bit 2 is the ratio LSB), phase-detector positive polarity = word[17], high charge-pump current = word[18], charge-pump high impedance = word[19], output/fast-lock select = word[21:20].
- R4: Feedback latch field map: swallow count = word[8:2], main counter = word[19:9], large prescaler modulus = word[20], power-down = word[21].
- R5: A load leaves the three latches that it does not select unchanged.
- R6: Each load pulses exactly one bit of `upd_strobe_o` for one system clock. The bit index equals the control code of R2. At all other times `upd_strobe_o` is zero.
- R7: `short_frame_o` is set by a load that comes after fewer than 22 serial clock edges since the previous load or reset, and cleared by a load that comes after 22 or more. It holds between loads. A short load still captures the register contents unchanged.
- R8: After reset, every decoded field, `upd_strobe_o` and `short_frame_o` are zero, and the shift register is zero.
- R9: Shifting and loading keep working while either channel's power-down bit is set.
- R10: Changes on `ser_data_i` with no rising edge of `ser_clk_i` do not alter the shift register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Serial shift clock |
| ser_data_i | input | 1 | Serial data, MSB first |
| ser_le_i | input | 1 | Load strobe; rising edge transfers the word |
| c1_ref_div_o | output | 15 | Channel 1 reference divide ratio |
| c1_pd_pos_o | output | 1 | Channel 1 phase detector positive polarity |
| c1_cp_high_o | output | 1 | Channel 1 high charge-pump current |
| c1_cp_hiz_o | output | 1 | Channel 1 charge pump high impedance |
| c1_out_sel_o | output | 2 | Channel 1 output / fast-lock select |
| c2_ref_div_o | output | 15 | Channel 2 reference divide ratio |
| c2_pd_pos_o | output | 1 | Channel 2 phase detector positive polarity |
| c2_cp_high_o | output | 1 | Channel 2 high charge-pump current |
| c2_cp_hiz_o | output | 1 | Channel 2 charge pump high impedance |
| c2_out_sel_o | output | 2 | Channel 2 output / fast-lock select |
| c1_swallow_o | output | 7 | Channel 1 swallow count |
| c1_prog_o | output | 11 | Channel 1 main counter value |
| c1_presc_big_o | output | 1 | Channel 1 large prescaler modulus |
| c1_pdown_o | output | 1 | Channel 1 power-down |
| c2_swallow_o | output | 7 | Channel 2 swallow count |
| c2_prog_o | output | 11 | Channel 2 main counter value |
| c2_presc_big_o | output | 1 | Channel 2 large prescaler modulus |
| c2_pdown_o | output | 1 | Channel 2 power-down |
| upd_strobe_o | output | 4 | One-cycle update pulse, bit index = control code |
| short_frame_o | output | 1 | Last load came after fewer than 22 bits |

## Verification
The hardest state to reach is a short load. Its captured word mixes bits left over from the previous frame with the few bits just sent, so a correct check needs an exact model of the shift register's history across loads. The stimulus interleaves random-length partial frames with full ones. The bench keeps its own copy of the shift register, updated bit by bit, so it knows both the mixed word and the expected flag. A directed case toggles the data line with the serial clock held low. It then reloads, to show that the register did not move.

// File: rtl/syn_cfg_pkg.sv
package syn_cfg_pkg;
    localparam int WORD_W     = 22;
    localparam int CODE_W     = 2;
    localparam int NUM_LATCH  = 1 << CODE_W;
    localparam int RDIV_W     = 15;
    localparam int SEL_W      = 2;
    localparam int SWAL_W     = 7;
    localparam int PROG_W     = 11;
    localparam int RDIV_LSB   = CODE_W;
    localparam int RMODE_LSB  = RDIV_LSB + RDIV_W;
    localparam int SWAL_LSB   = CODE_W;
    localparam int PROG_LSB   = SWAL_LSB + SWAL_W;
    localparam int FMODE_LSB  = PROG_LSB + PROG_W;
    localparam int CNT_W      = $clog2(WORD_W + 1);

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [CODE_W-1:0] {
        SEL_C2_REF = 2'b00,
        SEL_C1_REF = 2'b01,
        SEL_C2_FB  = 2'b10,
        SEL_C1_FB  = 2'b11
    } sel_e;

    typedef struct packed {
        logic [RDIV_W-1:0] div;
        logic              pd_pos;
        logic              cp_high;
        logic              cp_hiz;
        logic [SEL_W-1:0]  out_sel;
    } ref_fields_t;

    typedef struct packed {
        logic [SWAL_W-1:0] swallow;
        logic [PROG_W-1:0] prog;
        logic              presc_big;
        logic              pdown;
    } fb_fields_t;

    function automatic ref_fields_t decode_ref(input word_t w);
        ref_fields_t r;
        r.div     = w[RDIV_LSB +: RDIV_W];
        r.pd_pos  = w[RMODE_LSB];
        r.cp_high = w[RMODE_LSB + 1];
        r.cp_hiz  = w[RMODE_LSB + 2];
        r.out_sel = w[RMODE_LSB + 3 +: SEL_W];
        return r;
    endfunction

    function automatic fb_fields_t decode_fb(input word_t w);
        fb_fields_t f;
        f.swallow   = w[SWAL_LSB +: SWAL_W];
        f.prog      = w[PROG_LSB +: PROG_W];
        f.presc_big = w[FMODE_LSB];
        f.pdown     = w[FMODE_LSB + 1];
        return f;
    endfunction
endpackage

// File: rtl/ser_edge_sync.sv
module ser_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic sdat_i,
    input  logic le_i,
    output logic sclk_rise_o,
    output logic sdat_o,
    output logic le_rise_o
);
    typedef struct packed {
        logic [STAGES:0]   sclk;
        logic [STAGES:0]   le;
        logic [STAGES-1:0] dat;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sclk = {st_q.sclk[STAGES-1:0], sclk_i};
        st_d.le   = {st_q.le[STAGES-1:0], le_i};
        st_d.dat  = {st_q.dat[STAGES-2:0], sdat_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sclk_rise_o = st_q.sclk[STAGES-1] & ~st_q.sclk[STAGES];
    assign le_rise_o   = st_q.le[STAGES-1] & ~st_q.le[STAGES];
    assign sdat_o      = st_q.dat[STAGES-1];

    AST_SCLK_EDGE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_rise_o |=> !sclk_rise_o); // R1
    AST_LE_EDGE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        le_rise_o |=> !le_rise_o); // R6
endmodule

// File: rtl/ser_shift_reg.sv
module ser_shift_reg
    import syn_cfg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  shift_i,
    input  logic  din_i,
    input  logic  load_i,
    output word_t word_o,
    output logic  full_o
);
    typedef struct packed {
        word_t            sreg;
        logic [CNT_W-1:0] cnt;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (shift_i) sh_d.sreg = {sh_q.sreg[WORD_W-2:0], din_i};
        if (load_i)
            sh_d.cnt = shift_i ? CNT_W'(1) : '0;
        else if (shift_i && sh_q.cnt < CNT_W'(WORD_W))
            sh_d.cnt = sh_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign word_o = sh_q.sreg;
    assign full_o = (sh_q.cnt >= CNT_W'(WORD_W));

    AST_MSB_FIRST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        shift_i |=> word_o == {$past(word_o[WORD_W-2:0]), $past(din_i)}); // R1
    AST_NO_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_i |=> $stable(word_o)); // R10
    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        sh_q.cnt <= CNT_W'(WORD_W)); // R7
    AST_LOAD_RESTARTS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !shift_i) |=> !full_o); // R7
endmodule

// File: rtl/cfg_chan_regs.sv
module cfg_chan_regs
    import syn_cfg_pkg::*;
#(
    parameter logic [CODE_W-1:0] REF_CODE = SEL_C1_REF,
    parameter logic [CODE_W-1:0] FB_CODE  = SEL_C1_FB
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load_i,
    input  word_t       word_i,
    output ref_fields_t ref_o,
    output fb_fields_t  fb_o
);
    typedef struct packed {
        ref_fields_t rf;
        fb_fields_t  fb;
    } chan_t;

    chan_t ch_d, ch_q;
    logic  hit_ref, hit_fb;

    always_comb begin
        ch_d    = ch_q;
        hit_ref = load_i && (word_i[CODE_W-1:0] == REF_CODE);
        hit_fb  = load_i && (word_i[CODE_W-1:0] == FB_CODE);
        if (hit_ref) ch_d.rf = decode_ref(word_i);
        if (hit_fb)  ch_d.fb = decode_fb(word_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    assign ref_o = ch_q.rf;
    assign fb_o  = ch_q.fb;

    AST_REF_UNSELECTED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_i && word_i[CODE_W-1:0] == REF_CODE) |=> $stable(ref_o)); // R5
    AST_FB_UNSELECTED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_i && word_i[CODE_W-1:0] == FB_CODE) |=> $stable(fb_o)); // R5
    AST_REF_DIV_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && word_i[CODE_W-1:0] == REF_CODE) |=>
            ref_o.div == $past(word_i[RDIV_LSB +: RDIV_W])); // R3
    AST_FB_PDOWN_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && word_i[CODE_W-1:0] == FB_CODE) |=>
            fb_o.pdown == $past(word_i[WORD_W-1])); // R4
endmodule

// File: rtl/syn_cfg_loader.sv
module syn_cfg_loader
    import syn_cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk_i,
    input  logic              ser_data_i,
    input  logic              ser_le_i,
    output logic [RDIV_W-1:0] c1_ref_div_o,
    output logic              c1_pd_pos_o,
    output logic              c1_cp_high_o,
    output logic              c1_cp_hiz_o,
    output logic [SEL_W-1:0]  c1_out_sel_o,
    output logic [RDIV_W-1:0] c2_ref_div_o,
    output logic              c2_pd_pos_o,
    output logic              c2_cp_high_o,
    output logic              c2_cp_hiz_o,
    output logic [SEL_W-1:0]  c2_out_sel_o,
    output logic [SWAL_W-1:0] c1_swallow_o,
    output logic [PROG_W-1:0] c1_prog_o,
    output logic              c1_presc_big_o,
    output logic              c1_pdown_o,
    output logic [SWAL_W-1:0] c2_swallow_o,
    output logic [PROG_W-1:0] c2_prog_o,
    output logic              c2_presc_big_o,
    output logic              c2_pdown_o,
    output logic [NUM_LATCH-1:0] upd_strobe_o,
    output logic              short_frame_o
);
    logic  sclk_rise, sdat, le_rise, full;
    word_t word;
    ref_fields_t ref_f [2];
    fb_fields_t  fb_f  [2];

    ser_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .sclk_i(ser_clk_i), .sdat_i(ser_data_i), .le_i(ser_le_i),
        .sclk_rise_o(sclk_rise), .sdat_o(sdat), .le_rise_o(le_rise)
    );

    ser_shift_reg u_shift (
        .clk(clk), .rst_n(rst_n),
        .shift_i(sclk_rise), .din_i(sdat), .load_i(le_rise),
        .word_o(word), .full_o(full)
    );

    for (genvar g = 0; g < 2; g++) begin : g_chan
        localparam logic [CODE_W-1:0] RC = (g == 0) ? SEL_C1_REF : SEL_C2_REF;
        localparam logic [CODE_W-1:0] FC = (g == 0) ? SEL_C1_FB  : SEL_C2_FB;
        cfg_chan_regs #(.REF_CODE(RC), .FB_CODE(FC)) u_chan (
            .clk(clk), .rst_n(rst_n), .load_i(le_rise), .word_i(word),
            .ref_o(ref_f[g]), .fb_o(fb_f[g])
        );
    end

    typedef struct packed {
        logic [NUM_LATCH-1:0] strobe;
        logic                 short_fr;
    } top_t;

    top_t tp_d, tp_q;

    always_comb begin
        tp_d        = tp_q;
        tp_d.strobe = '0;
        if (le_rise) begin
            tp_d.strobe   = NUM_LATCH'(1) << word[CODE_W-1:0];
            tp_d.short_fr = ~full;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tp_q <= '0;
        else        tp_q <= tp_d;
    end

    assign upd_strobe_o   = tp_q.strobe;
    assign short_frame_o  = tp_q.short_fr;

    assign c1_ref_div_o   = ref_f[0].div;
    assign c1_pd_pos_o    = ref_f[0].pd_pos;
    assign c1_cp_high_o   = ref_f[0].cp_high;
    assign c1_cp_hiz_o    = ref_f[0].cp_hiz;
    assign c1_out_sel_o   = ref_f[0].out_sel;
    assign c2_ref_div_o   = ref_f[1].div;
    assign c2_pd_pos_o    = ref_f[1].pd_pos;
    assign c2_cp_high_o   = ref_f[1].cp_high;
    assign c2_cp_hiz_o    = ref_f[1].cp_hiz;
    assign c2_out_sel_o   = ref_f[1].out_sel;
    assign c1_swallow_o   = fb_f[0].swallow;
    assign c1_prog_o      = fb_f[0].prog;
    assign c1_presc_big_o = fb_f[0].presc_big;
    assign c1_pdown_o     = fb_f[0].pdown;
    assign c2_swallow_o   = fb_f[1].swallow;
    assign c2_prog_o      = fb_f[1].prog;
    assign c2_presc_big_o = fb_f[1].presc_big;
    assign c2_pdown_o     = fb_f[1].pdown;

    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(upd_strobe_o)); // R6
    AST_STROBE_FOLLOWS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        le_rise |=> $countones(upd_strobe_o) == 1); // R6
    AST_SHORT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !le_rise |=> $stable(short_frame_o)); // R7
    AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !le_rise |=> upd_strobe_o == '0); // R6
endmodule

// File: tb/syn_cfg_loader_bench.sv
`timescale 1ns/1ps
module syn_cfg_loader_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, sdat = 1'b0, sle = 1'b0;
    logic [14:0] c1_div, c2_div;
    logic c1_pol, c1_cph, c1_hiz, c2_pol, c2_cph, c2_hiz;
    logic [1:0] c1_sel, c2_sel;
    logic [6:0] c1_sw, c2_sw;
    logic [10:0] c1_pg, c2_pg;
    logic c1_pb, c1_pd, c2_pb, c2_pd;
    logic [3:0] stb;
    logic shortf;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [21:0] m_sreg = '0;
    int m_bits = 0;
    logic [21:0] m_lat [4];
    bit m_short = 0;
    int stb_cnt [4];

    always #2 clk = ~clk;

    syn_cfg_loader u_syn_cfg_loader (
        .clk(clk), .rst_n(rst_n),
        .ser_clk_i(sclk), .ser_data_i(sdat), .ser_le_i(sle),
        .c1_ref_div_o(c1_div), .c1_pd_pos_o(c1_pol), .c1_cp_high_o(c1_cph),
        .c1_cp_hiz_o(c1_hiz), .c1_out_sel_o(c1_sel),
        .c2_ref_div_o(c2_div), .c2_pd_pos_o(c2_pol), .c2_cp_high_o(c2_cph),
        .c2_cp_hiz_o(c2_hiz), .c2_out_sel_o(c2_sel),
        .c1_swallow_o(c1_sw), .c1_prog_o(c1_pg), .c1_presc_big_o(c1_pb), .c1_pdown_o(c1_pd),
        .c2_swallow_o(c2_sw), .c2_prog_o(c2_pg), .c2_presc_big_o(c2_pb), .c2_pdown_o(c2_pd),
        .upd_strobe_o(stb), .short_frame_o(shortf)
    );

    always @(negedge clk)
        for (int i = 0; i < 4; i++) if (stb[i]) stb_cnt[i]++;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // R3 reference map, R4 feedback map; latch index = control code (R2)
    function automatic int rdiv(input logic [21:0] w); return int'(w[16:2]); endfunction
    function automatic int rsel(input logic [21:0] w); return int'(w[21:20]); endfunction
    function automatic int fsw(input logic [21:0] w);  return int'(w[8:2]);   endfunction
    function automatic int fpg(input logic [21:0] w);  return int'(w[19:9]);  endfunction

    task automatic chk_eq(input string req, input string what, input int act, input int exp);
        chk(act == exp, req, what, act, exp);
    endtask

    task automatic check_outputs(input string req);
        chk_eq(req, "c1 ref div", int'(c1_div), rdiv(m_lat[1]));
        chk_eq(req, "c1 modes", int'({c1_sel, c1_hiz, c1_cph, c1_pol}), int'(m_lat[1][21:17]));
        chk_eq(req, "c2 ref div", int'(c2_div), rdiv(m_lat[0]));
        chk_eq(req, "c2 modes", int'({c2_sel, c2_hiz, c2_cph, c2_pol}), int'(m_lat[0][21:17]));
        chk_eq(req, "c1 sel", int'(c1_sel), rsel(m_lat[1]));
        chk_eq(req, "c1 swallow", int'(c1_sw), fsw(m_lat[3]));
        chk_eq(req, "c1 prog", int'(c1_pg), fpg(m_lat[3]));
        chk_eq(req, "c1 fb modes", int'({c1_pd, c1_pb}), int'(m_lat[3][21:20]));
        chk_eq(req, "c2 swallow", int'(c2_sw), fsw(m_lat[2]));
        chk_eq(req, "c2 prog", int'(c2_pg), fpg(m_lat[2]));
        chk_eq(req, "c2 fb modes", int'({c2_pd, c2_pb}), int'(m_lat[2][21:20]));
        chk_eq("R7", "short flag", int'(shortf), int'(m_short));
    endtask

    task automatic send_bits(input logic [21:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk); sdat = v[i];
            repeat (3) @(negedge clk); sclk = 1'b1;
            repeat (3) @(negedge clk); sclk = 1'b0;
            m_sreg = {m_sreg[20:0], v[i]};
            m_bits++;
        end
    endtask

    task automatic do_load(input string req);
        int code;
        for (int i = 0; i < 4; i++) stb_cnt[i] = 0;
        @(negedge clk); sle = 1'b1;
        repeat (8) @(negedge clk);
        code = int'(m_sreg[1:0]);
        m_lat[code] = m_sreg;
        m_short = (m_bits < 22);
        m_bits = 0;
        for (int i = 0; i < 4; i++)
            chk_eq("R6", $sformatf("strobe[%0d] pulses", i), stb_cnt[i], (i == code) ? 1 : 0);
        check_outputs(req);
        sle = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic full_load(input logic [21:0] w, input string req);
        send_bits(w, 22);
        do_load(req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        for (int i = 0; i < 4; i++) begin m_lat[i] = '0; stb_cnt[i] = 0; end
        repeat (5) @(negedge clk);
        // R8 reset state
        check_outputs("R8");
        chk_eq("R8", "strobe at reset", int'(stb), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 R2 R3: ch1 reference, minimum ratio, mixed modes
        full_load({2'b10, 1'b1, 1'b0, 1'b1, 15'd3, 2'b01}, "R3");
        // R3 R5: ch2 reference, maximum ratio, all modes set
        full_load({5'b11111, 15'd32767, 2'b00}, "R5");
        // R4 R9: ch1 feedback with power-down and large modulus
        full_load({1'b1, 1'b1, 11'd2047, 7'd127, 2'b11}, "R4");
        // R9: further loads while power-down is held
        full_load({1'b0, 1'b1, 11'd3, 7'd0, 2'b10}, "R9");
        full_load({5'b00000, 15'd1000, 2'b01}, "R9");
        chk_eq("R9", "c1 pdown still set", int'(c1_pd), 1);
        // R7 short frame: 5 bits only, old bits kept
        send_bits(22'b10110, 5);
        do_load("R7");
        full_load({5'b01010, 15'd777, 2'b00}, "R7");
        // R10: data toggles with no serial clock edge, then reload same word
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); sdat = ~sdat;
            repeat (3) @(negedge clk);
        end
        do_load("R10");
        // R1 MSB-first order: distinctive word on ch2 feedback
        full_load({1'b0, 1'b0, 11'b10000000001, 7'b1000001, 2'b10}, "R1");

        // Randomized frames, some short
        for (int n = 0; n < 60; n++) begin
            logic [21:0] w;
            w = 22'($urandom);
            if ($urandom_range(0, 5) == 0) begin
                send_bits(w, $urandom_range(1, 21));
                do_load("R7");
            end else begin
                full_load(w, "R2");
            end
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule